// File: doc/BRIEF.md
# Column-Driver DDR Lane Transmitter

This block sits at the output of a panel timing controller. It takes the wide parallel pixel word bound for the column drivers and moves it onto a small set of data lanes. Each lane carries two bits in every period of a forwarded clock: one for the rising half and one for the falling half. The column drivers can then capture data on both edges of that clock and need no local clock recovery. The default word holds two pixels of three colors at six bits each, which is 36 bits. That word goes out over 9 lanes in two consecutive clock periods (beats). Sync and control signals do not travel on the lanes.

The block drives the rising-half bit and the falling-half bit of each lane as separate logic signals. A DDR output register, or a behavioural model of one, combines them downstream. A forwarded-clock pair of the same form leaves alongside. A framing flag marks the first beat of every word. A 2-bit skew select delays all data lanes, and the framing flag, by 0 to 3 fast-clock cycles relative to the forwarded clock. This lets the launch point match the input delay of a given column driver. A data-enable input blanks a whole word to zeros while the forwarded clock keeps running.

Top module: `cdrv_ddr_tx`

## Requirements
- R1: Lane k on beat b carries word bit 18b+2k on its rising half (`lane_rise[k]`) and word bit 18b+2k+1 on its falling half (`lane_fall[k]`). This is the default of 9 lanes and 2 beats, so beat 0 covers bits 0..17 and beat 1 covers bits 18..35.
- R2: The word and its enable are sampled only on the first rising clock edge after reset release and on every second edge after that. Values presented at the other edges have no effect on the lanes.
- R3: Let S be the skew select. For a word sampled at edge E, beat 0 is on the outputs after edge E+1+S and beat 1 after edge E+2+S. Before the first beat arrives after reset, all lanes read zero.
- R4: The skew select is registered on every clock edge and delays every data lane and the framing flag by exactly S clock cycles (0..3) against the forwarded clock.
- R5: A word sampled with enable low drives zero on both halves of every lane in both of its beats.
- R6: From the first clock edge after reset release, the forwarded clock pair reads rising half 1 and falling half 0 every cycle, whatever the enable or the data.
- R7: `word_start` is 1 while the lanes carry beat 0 of a word and 0 while they carry beat 1. It is delayed by the same skew as the data.
- R8: While reset is asserted, every lane half, `word_start` and both forwarded-clock halves are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal clock; one beat per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_word | input | 36 | Parallel two-pixel color word |
| pix_de | input | 1 | Data enable; low blanks the sampled word |
| skew_sel | input | 2 | Lane delay in clock cycles, 0..3 |
| lane_rise | output | 9 | Rising-half bit of each data lane |
| lane_fall | output | 9 | Falling-half bit of each data lane |
| word_start | output | 1 | High on beat 0 of a word |
| fclk_rise | output | 1 | Rising-half level of the forwarded clock |
| fclk_fall | output | 1 | Falling-half level of the forwarded clock |

## Verification
On every cycle, the assertions check several things. The sample strobe fires at most every other edge, and the framing flag alternates. A blanked word leaves zeros in the lane stage. The delay-line output equals the lane stage from exactly S+1 cycles earlier for each of the four skew settings. The forwarded clock holds its levels, and reset clears every output. Two things only the scenarios can show. First, the actual bit-to-lane mapping, checked by rebuilding each 36-bit word from the two beats of all lanes. Second, that words presented between sample edges really are ignored across patterns such as all-ones, alternating bits and walking ones.

// File: rtl/cdrv_tx_pkg.sv
package cdrv_tx_pkg;

  // Default geometry of the pixel word and the lane bundle.
  localparam int unsigned DEF_COLOR_BITS = 6;
  localparam int unsigned DEF_COLORS     = 3;
  localparam int unsigned DEF_PIXELS     = 2;
  localparam int unsigned DEF_LANES      = 9;
  localparam int unsigned DEF_SKEW_W     = 2;

  // Bits carried per lane per forwarded-clock period (one per edge).
  localparam int unsigned BITS_PER_LANE  = 2;

  // Number of clock periods needed to send one word over the lanes.
  function automatic int unsigned beats_for(input int unsigned data_w,
                                            input int unsigned lanes);
    return data_w / (BITS_PER_LANE * lanes);
  endfunction

  // Word bit index carried by a lane in a given half (0 rise, 1 fall) and beat.
  function automatic int unsigned src_bit(input int unsigned lane,
                                          input int unsigned half,
                                          input int unsigned beat,
                                          input int unsigned lanes);
    return (BITS_PER_LANE * lanes * beat) + (BITS_PER_LANE * lane) + half;
  endfunction

  // Width of a counter that walks the beats of one word.
  function automatic int unsigned beat_w_for(input int unsigned beats);
    return (beats > 1) ? $clog2(beats) : 1;
  endfunction

endpackage

// File: rtl/cdrv_beat_seq.sv
module cdrv_beat_seq #(
  parameter int unsigned BEATS  = 2,
  parameter int unsigned BEAT_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              cap_load,
  output logic [BEAT_W-1:0] beat_idx
);

  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  logic [BEAT_W-1:0] bcnt_q;

  // Free-running beat counter; beat 0 is the sampling cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q <= '0;
    end else if (bcnt_q == LAST_BEAT) begin
      bcnt_q <= '0;
    end else begin
      bcnt_q <= bcnt_q + BEAT_W'(1);
    end
  end

  assign cap_load = (bcnt_q == '0);
  assign beat_idx = bcnt_q;

endmodule

// File: rtl/cdrv_lane_packer.sv
module cdrv_lane_packer
  import cdrv_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned LANES  = 9,
  parameter int unsigned BEATS  = 2,
  parameter int unsigned BEAT_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_load,
  input  logic [BEAT_W-1:0] beat_idx,
  input  logic [DATA_W-1:0] pix_word,
  input  logic              pix_de,
  output logic [2*LANES:0]  slice_word
);

  localparam int unsigned SLICE_W = 2 * LANES + 1;

  logic [DATA_W-1:0] gated_word;
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] src_word;
  logic [LANES-1:0]  rise_b [BEATS];
  logic [LANES-1:0]  fall_b [BEATS];
  logic [SLICE_W-1:0] slice_q;

  // Enable gate applied once, at sampling, to the whole word.
  assign gated_word = pix_de ? pix_word : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (cap_load) begin
      hold_q <= gated_word;
    end
  end

  // Beat 0 reads the incoming word directly; later beats read the hold copy.
  assign src_word = cap_load ? gated_word : hold_q;

  // Fixed bit-to-lane map per beat.
  for (genvar b = 0; b < BEATS; b++) begin : g_beat
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign rise_b[b][k] = src_word[src_bit(k, 0, b, LANES)];
      assign fall_b[b][k] = src_word[src_bit(k, 1, b, LANES)];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slice_q <= '0;
    end else begin
      slice_q <= {cap_load, rise_b[beat_idx], fall_b[beat_idx]};
    end
  end

  assign slice_word = slice_q;

endmodule

// File: rtl/cdrv_skew_line.sv
module cdrv_skew_line #(
  parameter int unsigned WIDTH  = 19,
  parameter int unsigned SKEW_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SKEW_W-1:0] skew_sel,
  input  logic [WIDTH-1:0]  din,
  output logic [SKEW_W-1:0] skew_q,
  output logic [WIDTH-1:0]  dout
);

  localparam int unsigned NTAPS = 1 << SKEW_W;

  logic [WIDTH-1:0]  tap [NTAPS];
  logic [SKEW_W-1:0] skew_r;
  logic [WIDTH-1:0]  dout_q;

  assign tap[0] = din;

  // One register per skew step.
  for (genvar i = 1; i < NTAPS; i++) begin : g_tap
    logic [WIDTH-1:0] stage_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= '0;
      end else begin
        stage_q <= tap[i-1];
      end
    end
    assign tap[i] = stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skew_r <= '0;
      dout_q <= '0;
    end else begin
      skew_r <= skew_sel;
      dout_q <= tap[skew_r];
    end
  end

  assign skew_q = skew_r;
  assign dout   = dout_q;

endmodule

// File: rtl/cdrv_clk_fwd.sv
module cdrv_clk_fwd #(
  parameter bit INVERT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  output logic fclk_rise,
  output logic fclk_fall
);

  logic rise_q;
  logic fall_q;

  // Forwarded clock as a DDR pair: one level per half period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= ~INVERT;
      fall_q <= INVERT;
    end
  end

  assign fclk_rise = rise_q;
  assign fclk_fall = fall_q;

endmodule

// File: rtl/cdrv_ddr_tx.sv
module cdrv_ddr_tx
  import cdrv_tx_pkg::*;
#(
  parameter int unsigned COLOR_BITS = DEF_COLOR_BITS,
  parameter int unsigned COLORS     = DEF_COLORS,
  parameter int unsigned PIXELS     = DEF_PIXELS,
  parameter int unsigned LANES      = DEF_LANES,
  parameter int unsigned SKEW_W     = DEF_SKEW_W,
  parameter int unsigned DATA_W     = COLOR_BITS * COLORS * PIXELS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] pix_word,
  input  logic              pix_de,
  input  logic [SKEW_W-1:0] skew_sel,
  output logic [LANES-1:0]  lane_rise,
  output logic [LANES-1:0]  lane_fall,
  output logic              word_start,
  output logic              fclk_rise,
  output logic              fclk_fall
);

  localparam int unsigned BEATS   = beats_for(DATA_W, LANES);
  localparam int unsigned BEAT_W  = beat_w_for(BEATS);
  localparam int unsigned SLICE_W = 2 * LANES + 1;

  // Named internal events, also observed by the bound checker.
  logic               cap_load;
  logic [BEAT_W-1:0]  beat_idx;
  logic [SLICE_W-1:0] slice_word;
  logic [SKEW_W-1:0]  skew_q;
  logic [SLICE_W-1:0] line_out;

  cdrv_beat_seq #(
    .BEATS  (BEATS),
    .BEAT_W (BEAT_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_load (cap_load),
    .beat_idx (beat_idx)
  );

  cdrv_lane_packer #(
    .DATA_W (DATA_W),
    .LANES  (LANES),
    .BEATS  (BEATS),
    .BEAT_W (BEAT_W)
  ) u_pack (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_load   (cap_load),
    .beat_idx   (beat_idx),
    .pix_word   (pix_word),
    .pix_de     (pix_de),
    .slice_word (slice_word)
  );

  cdrv_skew_line #(
    .WIDTH  (SLICE_W),
    .SKEW_W (SKEW_W)
  ) u_skew (
    .clk      (clk),
    .rst_n    (rst_n),
    .skew_sel (skew_sel),
    .din      (slice_word),
    .skew_q   (skew_q),
    .dout     (line_out)
  );

  cdrv_clk_fwd #(
    .INVERT (1'b0)
  ) u_fclk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fclk_rise (fclk_rise),
    .fclk_fall (fclk_fall)
  );

  assign word_start = line_out[SLICE_W-1];
  assign lane_rise  = line_out[2*LANES-1:LANES];
  assign lane_fall  = line_out[LANES-1:0];

endmodule

// File: rtl/cdrv_ddr_tx_chk.sv
module cdrv_ddr_tx_chk #(
  parameter int unsigned LANES  = 9,
  parameter int unsigned SKEW_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pix_de,
  input logic               cap_load,
  input logic [2*LANES:0]   slice_word,
  input logic [SKEW_W-1:0]  skew_q,
  input logic [2*LANES:0]   line_out,
  input logic [LANES-1:0]   lane_rise,
  input logic [LANES-1:0]   lane_fall,
  input logic               word_start,
  input logic               fclk_rise,
  input logic               fclk_fall
);

  assert_sample_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_load |=> !cap_load);

  assert_blank_beat0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_load && !pix_de) |=> (slice_word[2*LANES-1:0] == '0));

  assert_blank_beat1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_load && !pix_de) |=> ##1 (slice_word[2*LANES-1:0] == '0));

  assert_skew0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (skew_q == SKEW_W'(0)) |=> (line_out == $past(slice_word, 1)));

  assert_skew1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (skew_q == SKEW_W'(1)) |=> (line_out == $past(slice_word, 2)));

  assert_skew2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (skew_q == SKEW_W'(2)) |=> (line_out == $past(slice_word, 3)));

  assert_skew3_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (skew_q == SKEW_W'(3)) |=> (line_out == $past(slice_word, 4)));

  assert_frame_alt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    word_start |=> !word_start);

  assert_fwd_clk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (fclk_rise && !fclk_fall));

  assert_reset_out_R8: assert property (@(posedge clk)
    !rst_n |-> (lane_rise == '0 && lane_fall == '0 && !word_start
                && !fclk_rise && !fclk_fall));

endmodule

bind cdrv_ddr_tx cdrv_ddr_tx_chk #(
  .LANES  (LANES),
  .SKEW_W (SKEW_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pix_de     (pix_de),
  .cap_load   (cap_load),
  .slice_word (slice_word),
  .skew_q     (skew_q),
  .line_out   (line_out),
  .lane_rise  (lane_rise),
  .lane_fall  (lane_fall),
  .word_start (word_start),
  .fclk_rise  (fclk_rise),
  .fclk_fall  (fclk_fall)
);

// File: tb/tb_cdrv_ddr_tx.sv
module tb_cdrv_ddr_tx;

  localparam int L  = 9;
  localparam int DW = 36;
  localparam int NWORDS = 14;

  typedef struct packed {
    logic         first;
    logic [L-1:0] r;
    logic [L-1:0] f;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] pix_word = '0;
  logic          pix_de = 1'b0;
  logic [1:0]    skew_sel = 2'd0;
  logic [L-1:0]  lane_rise, lane_fall;
  logic          word_start, fclk_rise, fclk_fall;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  item_t exp_q[$];

  always #2 clk = ~clk;

  cdrv_ddr_tx dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_word   (pix_word),
    .pix_de     (pix_de),
    .skew_sel   (skew_sel),
    .lane_rise  (lane_rise),
    .lane_fall  (lane_fall),
    .word_start (word_start),
    .fclk_rise  (fclk_rise),
    .fclk_fall  (fclk_fall)
  );

  function automatic logic [DW-1:0] pattern(input int idx);
    case (idx)
      0: return '1;
      1: return '0;
      2: return 36'hAAAAAAAAA;
      3: return 36'h555555555;
      default: return (36'h1 << (idx % DW)) ^ (36'(idx) * 36'h9E3779B1);
    endcase
  endfunction

  // Driver side: expected beats, built bit by bit from the word index.
  task automatic push_word(input logic [DW-1:0] w, input logic de);
    item_t it [2];
    it[0] = '0;
    it[1] = '0;
    it[0].first = 1'b1;
    for (int i = 0; i < DW; i++) begin
      int b, ln;
      b  = i / (2 * L);
      ln = (i % (2 * L)) / 2;
      if (i % 2 == 0) it[b].r[ln] = de & w[i];
      else            it[b].f[ln] = de & w[i];
    end
    exp_q.push_back(it[0]);
    exp_q.push_back(it[1]);
  endtask

  task automatic check(input bit ok, input string req,
                       input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  // Monitor side: one comparison per cycle, after the edge count e.
  task automatic monitor(input int e, input int s);
    item_t got, exp;
    got = {word_start, lane_rise, lane_fall};
    if (e >= 1)
      check(fclk_rise === 1'b1 && fclk_fall === 1'b0, "R6 fwd clock",
            {62'd0, fclk_rise, fclk_fall}, 64'd2);
    if (e >= 2 + s && exp_q.size() > 0) begin
      exp = exp_q.pop_front();
      check(got === exp, "R1 R3 R4 R5 R7 lane beat", 64'(got), 64'(exp));
    end else begin
      check(got === '0, "R3 idle before latency", 64'(got), 64'd0);
    end
  endtask

  task automatic run_phase(input int s, input int seed);
    int e;
    rst_n    = 1'b0;
    skew_sel = 2'(s);
    pix_word = '1;
    pix_de   = 1'b1;
    exp_q.delete();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check({lane_rise, lane_fall, word_start, fclk_rise, fclk_fall} === '0,
            "R8 reset", 64'({lane_rise, lane_fall, word_start, fclk_rise, fclk_fall}), 64'd0);
    end
    rst_n = 1'b1;
    e = 0;
    for (int c = 0; c < 2 * NWORDS + 10; c++) begin
      if (c % 2 == 0) begin
        int wi;
        logic de;
        wi = c / 2 + seed;
        de = (c < 2 * NWORDS) ? ((wi % 5) != 3) : 1'b0;
        pix_word = pattern(wi);
        pix_de   = de;
        push_word(pattern(wi), de);
      end else begin
        // R2: values at non-sampling edges must not reach the lanes
        pix_word = ~pix_word ^ 36'h0F0F0F0F0;
        pix_de   = ~pix_de;
      end
      @(negedge clk);
      e++;
      monitor(e, s);
    end
  endtask

  initial begin
    run_phase(0, 0);
    run_phase(1, 3);
    run_phase(2, 5);
    run_phase(3, 8);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired R3 got=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule